// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block holds the event counters that an Ethernet MAC keeps for the frames it receives and sends. The receive path reports each finished frame once. That report carries the frame's byte length, whether it carried a VLAN tag, whether its FCS was bad, whether it had an alignment error, and whether the maximum-length logic cut it short. From this report the block keeps a receive jabber count.

The transmit path reports two kinds of event. It gives a strobe for every byte cycle on the wire, with a flag that marks overhead bytes (preamble, SFD, jam). It also gives one end-of-frame report with the frame's collision count and its event flags. From these the block keeps a byte count, a frame count, and a set of per-event frame counts.

Software reaches every counter through a simple word-indexed register port. It can read any counter combinationally and write it in one cycle, which is how it clears or preloads a counter. All counters saturate at their all-ones value rather than wrapping.

Top module: `mac_stat_bank`

## Requirements
- R1: After a synchronous active-low reset, every word index reads 0.
- R2: Word 0, the receive jabber count, goes up by one for a reported frame with a bad FCS whose length is over 1518 bytes untagged, or over 1522 bytes tagged. Frames at or below those lengths, and frames with a good FCS and no alignment error, leave it unchanged.
- R3: For the jabber rule, an alignment error counts the same as a bad FCS.
- R4: A frame reported as truncated by the maximum-length logic never increments the receive jabber count.
- R5: Word 1, the transmit byte count, goes up by one for each byte strobe whose overhead flag is 0. This includes the data bytes of frames that are cut short by a collision. Strobes with the overhead flag at 1 (preamble, SFD, jam) are not counted.
- R6: The following counters each go up by one per transmit end-of-frame report:
  - word 2 (frames) on every report;
  - the other counters only when their flag is set in that report: multicast at word 3, broadcast at 4, deferred at 6, excessively deferred at 7, late collision at 10, excessive collision at 11, jabber at 15, bad FCS at 16, oversize at 18, undersize at 19, and fragment at 20.
- R7: The collision counters work as follows:
  - word 8 counts frames sent successfully after exactly one collision;
  - word 9 counts frames sent successfully after 2 to 15 collisions;
  - word 12 adds each reported frame's collision count.
- R8: Words 5, 13, 14 and 17, and every index above 20, read as 0 and ignore writes.
- R9: Field widths are as follows, all right-aligned:
  - the receive jabber count is 12 bits;
  - the byte count is 24 bits;
  - every other counter is EVT_W bits (16 by default).
  Bits above a field read as 0 and writes to them are dropped.
- R10: A software write to a counter in the same cycle as a hardware increment to that counter wins, and that increment is lost.
- R11: A counter at its all-ones value stays there on further increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_done | input | 1 | Receive end-of-frame report valid |
| rx_len | input | LEN_W | Received frame length in bytes |
| rx_tagged | input | 1 | Received frame carried a VLAN tag |
| rx_crc_bad | input | 1 | Received frame FCS invalid |
| rx_align_bad | input | 1 | Received frame had an alignment error |
| rx_cut | input | 1 | Frame was truncated by the maximum-length logic |
| tx_byte_stb | input | 1 | One byte driven on the wire this cycle |
| tx_byte_ovh | input | 1 | That byte is preamble, SFD or jam |
| tx_done | input | 1 | Transmit end-of-frame report valid |
| tx_sent_ok | input | 1 | Frame was finally sent successfully |
| tx_mcast | input | 1 | Multicast destination |
| tx_bcast | input | 1 | Broadcast destination |
| tx_deferred | input | 1 | Frame was deferred |
| tx_xdeferred | input | 1 | Frame was excessively deferred |
| tx_coll_cnt | input | 5 | Collisions seen by this frame |
| tx_late_coll | input | 1 | Late collision |
| tx_xs_coll | input | 1 | Excessive collisions |
| tx_jabber | input | 1 | Transmit jabber |
| tx_crc_bad | input | 1 | Transmitted FCS error |
| tx_oversize | input | 1 | Oversize frame |
| tx_undersize | input | 1 | Undersize frame |
| tx_fragment | input | 1 | Fragment frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |

## Verification
The hardest case to reach from the ports is the jabber length boundary. Only one side of the 1518/1522 step, and only some combinations of tag, error kind and truncation, should count. The bench therefore sweeps every combination across a window of lengths around both limits and checks the count after each frame.

Saturation and the write-versus-increment race would take millions of frames to reach naturally. The bench instead preloads counters to all-ones or near all-ones through the write port, and it drives a write and an increment in the same cycle.

// File: rtl/mac_stat_pkg.sv
// Shared constants, word map and event bundle for the MAC statistics bank.
// Assumes the word map is fixed; only widths are parameters of the top.
package mac_stat_pkg;

    localparam int NUM_WORDS = 21;
    localparam int INC_W     = 5;

    localparam int IDX_RX_JABBER = 0;
    localparam int IDX_TX_BYTES  = 1;
    localparam int IDX_TX_FRAMES = 2;
    localparam int IDX_TX_MCAST  = 3;
    localparam int IDX_TX_BCAST  = 4;
    localparam int IDX_TX_DEFER  = 6;
    localparam int IDX_TX_XDEFER = 7;
    localparam int IDX_TX_COL1   = 8;
    localparam int IDX_TX_COLN   = 9;
    localparam int IDX_TX_LATE   = 10;
    localparam int IDX_TX_XCOL   = 11;
    localparam int IDX_TX_COLSUM = 12;
    localparam int IDX_TX_JABBER = 15;
    localparam int IDX_TX_BADFCS = 16;
    localparam int IDX_TX_OVER   = 18;
    localparam int IDX_TX_UNDER  = 19;
    localparam int IDX_TX_FRAG   = 20;

    // Transmit events produced for one cycle
    typedef struct packed {
        logic             frame;
        logic             mcast;
        logic             bcast;
        logic             defer;
        logic             xdefer;
        logic             col1;
        logic             coln;
        logic             late;
        logic             xcol;
        logic             jabber;
        logic             badfcs;
        logic             over;
        logic             under;
        logic             frag;
        logic             byte_inc;
        logic [INC_W-1:0] colsum;
    } tx_evt_t;

    // True for word slots that hold no counter
    function automatic bit is_reserved(input int idx);
        return (idx == 5) || (idx == 13) || (idx == 14) || (idx == 17);
    endfunction

    // Width of the counter held in a word slot
    function automatic int word_width(input int idx, input int rxj_w,
                                      input int byte_w, input int evt_w);
        if (idx == IDX_RX_JABBER) return rxj_w;
        if (idx == IDX_TX_BYTES)  return byte_w;
        return evt_w;
    endfunction

endpackage

// File: rtl/mac_stat_counter.sv
// Saturating counter with a software load port.
// A load in the same cycle as an increment takes precedence.
// Assumes W + 1 >= INC_W.
module mac_stat_counter #(
    parameter int W     = 16,
    parameter int INC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_val,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     q
);

    logic [W:0] sum;

    // Widened sum so that a carry out marks overflow
    always_comb sum = {1'b0, q} + (W+1)'(inc);

    // Reset, load, or saturating add
    always_ff @(posedge clk) begin
        if (!rst_n)              q <= '0;
        else if (wr_en)          q <= wr_val;
        else if (inc != '0) begin
            if (sum[W])          q <= '1;
            else                 q <= sum[W-1:0];
        end
    end

endmodule

// File: rtl/mac_stat_rx_qual.sv
// Receive frame qualification for the jabber count.
// A frame counts when it is longer than the limit for its tag state, has a
// bad FCS or an alignment error, and was not cut by the length limiter.
module mac_stat_rx_qual #(
    parameter int LEN_W     = 16,
    parameter int MAX_PLAIN = 1518,
    parameter int TAG_EXTRA = 4
) (
    input  logic             rx_done,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             rx_tagged,
    input  logic             rx_crc_bad,
    input  logic             rx_align_bad,
    input  logic             rx_cut,
    output logic             jabber_hit
);

    localparam logic [LEN_W-1:0] LIM_PLAIN = LEN_W'(MAX_PLAIN);
    localparam logic [LEN_W-1:0] LIM_TAG   = LEN_W'(MAX_PLAIN + TAG_EXTRA);

    logic [LEN_W-1:0] limit;

    // Length limit chosen by tag state
    always_comb limit = rx_tagged ? LIM_TAG : LIM_PLAIN;

    // Jabber qualification
    always_comb jabber_hit = rx_done && !rx_cut && (rx_len > limit)
                             && (rx_crc_bad || rx_align_bad);

endmodule

// File: rtl/mac_stat_tx_qual.sv
// Transmit event classification. Turns byte strobes and end-of-frame status
// into one event bundle per cycle. Assumes overhead bytes are flagged by
// the MAC and that end-of-frame status is valid only with tx_done.
module mac_stat_tx_qual
    import mac_stat_pkg::*;
(
    input  logic             tx_byte_stb,
    input  logic             tx_byte_ovh,
    input  logic             tx_done,
    input  logic             tx_sent_ok,
    input  logic             tx_mcast,
    input  logic             tx_bcast,
    input  logic             tx_deferred,
    input  logic             tx_xdeferred,
    input  logic [INC_W-1:0] tx_coll_cnt,
    input  logic             tx_late_coll,
    input  logic             tx_xs_coll,
    input  logic             tx_jabber,
    input  logic             tx_crc_bad,
    input  logic             tx_oversize,
    input  logic             tx_undersize,
    input  logic             tx_fragment,
    output tx_evt_t          ev
);

    logic ok_done;
    logic multi;

    // Successful completion and multi-collision range
    always_comb begin
        ok_done = tx_done && tx_sent_ok;
        multi   = (tx_coll_cnt >= INC_W'(2)) && (tx_coll_cnt <= INC_W'(15));
    end

    // Event bundle assembly
    always_comb begin
        ev.frame    = tx_done;
        ev.mcast    = tx_done && tx_mcast;
        ev.bcast    = tx_done && tx_bcast;
        ev.defer    = tx_done && tx_deferred;
        ev.xdefer   = tx_done && tx_xdeferred;
        ev.col1     = ok_done && (tx_coll_cnt == INC_W'(1));
        ev.coln     = ok_done && multi;
        ev.late     = tx_done && tx_late_coll;
        ev.xcol     = tx_done && tx_xs_coll;
        ev.jabber   = tx_done && tx_jabber;
        ev.badfcs   = tx_done && tx_crc_bad;
        ev.over     = tx_done && tx_oversize;
        ev.under    = tx_done && tx_undersize;
        ev.frag     = tx_done && tx_fragment;
        ev.byte_inc = tx_byte_stb && !tx_byte_ovh;
        ev.colsum   = tx_done ? tx_coll_cnt : '0;
    end

endmodule

// File: rtl/mac_stat_bank.sv
// Ethernet MAC statistics counter bank: receive jabber count plus the
// transmit counter set, in a fixed word map behind a simple register port.
// Reads are combinational, writes take one cycle. Reserved and unmapped
// words read zero. Assumes a single clock domain for MAC status and software.
module mac_stat_bank
    import mac_stat_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int LEN_W     = 16,
    parameter int RXJ_W     = 12,
    parameter int BYTE_W    = 24,
    parameter int EVT_W     = 16,
    parameter int MAX_PLAIN = 1518,
    parameter int TAG_EXTRA = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_done,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              rx_tagged,
    input  logic              rx_crc_bad,
    input  logic              rx_align_bad,
    input  logic              rx_cut,
    input  logic              tx_byte_stb,
    input  logic              tx_byte_ovh,
    input  logic              tx_done,
    input  logic              tx_sent_ok,
    input  logic              tx_mcast,
    input  logic              tx_bcast,
    input  logic              tx_deferred,
    input  logic              tx_xdeferred,
    input  logic [4:0]        tx_coll_cnt,
    input  logic              tx_late_coll,
    input  logic              tx_xs_coll,
    input  logic              tx_jabber,
    input  logic              tx_crc_bad,
    input  logic              tx_oversize,
    input  logic              tx_undersize,
    input  logic              tx_fragment,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    logic                          rx_jab;
    tx_evt_t                       tx_ev;
    logic [INC_W-1:0]              inc_amt [NUM_WORDS];
    logic [NUM_WORDS-1:0]          wr_hit;
    logic [NUM_WORDS-1:0][31:0]    rd_word;
    logic                          unused_bits;

    mac_stat_rx_qual #(
        .LEN_W(LEN_W), .MAX_PLAIN(MAX_PLAIN), .TAG_EXTRA(TAG_EXTRA)
    ) u_rx (
        .rx_done(rx_done), .rx_len(rx_len), .rx_tagged(rx_tagged),
        .rx_crc_bad(rx_crc_bad), .rx_align_bad(rx_align_bad),
        .rx_cut(rx_cut), .jabber_hit(rx_jab)
    );

    mac_stat_tx_qual u_tx (
        .tx_byte_stb(tx_byte_stb), .tx_byte_ovh(tx_byte_ovh),
        .tx_done(tx_done), .tx_sent_ok(tx_sent_ok),
        .tx_mcast(tx_mcast), .tx_bcast(tx_bcast),
        .tx_deferred(tx_deferred), .tx_xdeferred(tx_xdeferred),
        .tx_coll_cnt(tx_coll_cnt), .tx_late_coll(tx_late_coll),
        .tx_xs_coll(tx_xs_coll), .tx_jabber(tx_jabber),
        .tx_crc_bad(tx_crc_bad), .tx_oversize(tx_oversize),
        .tx_undersize(tx_undersize), .tx_fragment(tx_fragment),
        .ev(tx_ev)
    );

    // Route classified events to their word slots
    always_comb begin
        for (int i = 0; i < NUM_WORDS; i++) inc_amt[i] = '0;
        inc_amt[IDX_RX_JABBER] = INC_W'(rx_jab);
        inc_amt[IDX_TX_BYTES]  = INC_W'(tx_ev.byte_inc);
        inc_amt[IDX_TX_FRAMES] = INC_W'(tx_ev.frame);
        inc_amt[IDX_TX_MCAST]  = INC_W'(tx_ev.mcast);
        inc_amt[IDX_TX_BCAST]  = INC_W'(tx_ev.bcast);
        inc_amt[IDX_TX_DEFER]  = INC_W'(tx_ev.defer);
        inc_amt[IDX_TX_XDEFER] = INC_W'(tx_ev.xdefer);
        inc_amt[IDX_TX_COL1]   = INC_W'(tx_ev.col1);
        inc_amt[IDX_TX_COLN]   = INC_W'(tx_ev.coln);
        inc_amt[IDX_TX_LATE]   = INC_W'(tx_ev.late);
        inc_amt[IDX_TX_XCOL]   = INC_W'(tx_ev.xcol);
        inc_amt[IDX_TX_COLSUM] = tx_ev.colsum;
        inc_amt[IDX_TX_JABBER] = INC_W'(tx_ev.jabber);
        inc_amt[IDX_TX_BADFCS] = INC_W'(tx_ev.badfcs);
        inc_amt[IDX_TX_OVER]   = INC_W'(tx_ev.over);
        inc_amt[IDX_TX_UNDER]  = INC_W'(tx_ev.under);
        inc_amt[IDX_TX_FRAG]   = INC_W'(tx_ev.frag);
    end

    // Decode software write strobes per word
    always_comb begin
        for (int i = 0; i < NUM_WORDS; i++)
            wr_hit[i] = reg_wr && (reg_addr == ADDR_W'(i));
    end

    // One counter per mapped word; reserved slots are tied to zero
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        if (is_reserved(g)) begin : g_rsv
            assign rd_word[g] = '0;
        end else begin : g_cnt
            localparam int CW = word_width(g, RXJ_W, BYTE_W, EVT_W);
            logic [CW-1:0] q;
            mac_stat_counter #(.W(CW), .INC_W(INC_W)) u_cnt (
                .clk(clk), .rst_n(rst_n), .wr_en(wr_hit[g]),
                .wr_val(reg_wdata[CW-1:0]), .inc(inc_amt[g]), .q(q)
            );
            assign rd_word[g] = 32'(q);
        end
    end

    // Read multiplexer; unmapped indices return zero
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_WORDS; i++)
            if (reg_addr == ADDR_W'(i)) reg_rdata = rd_word[i];
    end

    assign unused_bits = ^{reg_wdata, wr_hit};

endmodule

// File: rtl/mac_stat_bank_chk.sv
// Property checker for mac_stat_bank, attached by bind. Observes the
// register port, the MAC status inputs and the per-word read values.
module mac_stat_bank_chk #(
    parameter int ADDR_W    = 5,
    parameter int LEN_W     = 16,
    parameter int RXJ_W     = 12,
    parameter int BYTE_W    = 24,
    parameter int NW        = 21,
    parameter int MAX_PLAIN = 1518,
    parameter int TAG_EXTRA = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rx_done,
    input logic [LEN_W-1:0]       rx_len,
    input logic                   rx_tagged,
    input logic                   rx_crc_bad,
    input logic                   rx_align_bad,
    input logic                   rx_cut,
    input logic                   tx_byte_stb,
    input logic                   tx_byte_ovh,
    input logic                   reg_wr,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic [31:0]            reg_wdata,
    input logic [31:0]            reg_rdata,
    input logic [NW-1:0][31:0]    rd_word
);

    logic              wr0, wr1, short_frame;
    logic [RXJ_W-1:0]  rxj;
    logic [BYTE_W-1:0] byt;
    logic              unused_chk;

    always_comb begin
        wr0 = reg_wr && (reg_addr == ADDR_W'(0));
        wr1 = reg_wr && (reg_addr == ADDR_W'(1));
        rxj = rd_word[0][RXJ_W-1:0];
        byt = rd_word[1][BYTE_W-1:0];
        short_frame = rx_len <= (rx_tagged ? LEN_W'(MAX_PLAIN + TAG_EXTRA)
                                           : LEN_W'(MAX_PLAIN));
    end

    assign unused_chk = ^{rd_word, reg_wdata};

    AST_RXJ_GOOD_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && !rx_crc_bad && !rx_align_bad && !wr0 |=> $stable(rxj)); // R2
    AST_RXJ_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && short_frame && !wr0 |=> $stable(rxj)); // R2
    AST_RXJ_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && rx_align_bad && !rx_cut && !short_frame && !wr0
        && (rxj != '1) |=> rxj == $past(rxj) + 1'b1); // R3
    AST_RXJ_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && rx_cut && !wr0 |=> $stable(rxj)); // R4
    AST_BYTE_OVH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_byte_stb && tx_byte_ovh && !wr1 |=> $stable(byt)); // R5
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(5)) |-> reg_rdata == 32'd0); // R8
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(0)) |-> reg_rdata[31:RXJ_W] == '0); // R9
    AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr0 |=> rxj == $past(reg_wdata[RXJ_W-1:0])); // R10
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rxj == '1) && !wr0 |=> rxj == '1); // R11

endmodule

bind mac_stat_bank mac_stat_bank_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .RXJ_W(RXJ_W), .BYTE_W(BYTE_W),
    .NW(mac_stat_pkg::NUM_WORDS), .MAX_PLAIN(MAX_PLAIN), .TAG_EXTRA(TAG_EXTRA)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_len(rx_len),
    .rx_tagged(rx_tagged), .rx_crc_bad(rx_crc_bad),
    .rx_align_bad(rx_align_bad), .rx_cut(rx_cut),
    .tx_byte_stb(tx_byte_stb), .tx_byte_ovh(tx_byte_ovh),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rd_word(rd_word)
);

// File: tb/mac_stat_bank_test.sv
// Self-checking bench: reset sweep, receive jabber sweep around both length
// limits, transmit frame sweep, then write/saturation/reserved corner cases.
module mac_stat_bank_test;

    localparam int PERIOD = 10;
    localparam int EVT_W  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_done = 0, rx_tagged = 0, rx_crc_bad = 0;
    logic        rx_align_bad = 0, rx_cut = 0;
    logic [15:0] rx_len = '0;
    logic        tx_byte_stb = 0, tx_byte_ovh = 0, tx_done = 0, tx_sent_ok = 0;
    logic        tx_mcast = 0, tx_bcast = 0, tx_deferred = 0, tx_xdeferred = 0;
    logic [4:0]  tx_coll_cnt = '0;
    logic        tx_late_coll = 0, tx_xs_coll = 0, tx_jabber = 0, tx_crc_bad = 0;
    logic        tx_oversize = 0, tx_undersize = 0, tx_fragment = 0;
    logic        reg_wr = 0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int failures = 0;
    int exp_w [21];
    int rxj_exp = 0;
    int flag_word [11] = '{3, 4, 6, 7, 10, 11, 15, 16, 18, 19, 20};

    always #(PERIOD/2) clk = ~clk;

    mac_stat_bank uut (
        .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_len(rx_len),
        .rx_tagged(rx_tagged), .rx_crc_bad(rx_crc_bad),
        .rx_align_bad(rx_align_bad), .rx_cut(rx_cut),
        .tx_byte_stb(tx_byte_stb), .tx_byte_ovh(tx_byte_ovh),
        .tx_done(tx_done), .tx_sent_ok(tx_sent_ok), .tx_mcast(tx_mcast),
        .tx_bcast(tx_bcast), .tx_deferred(tx_deferred),
        .tx_xdeferred(tx_xdeferred), .tx_coll_cnt(tx_coll_cnt),
        .tx_late_coll(tx_late_coll), .tx_xs_coll(tx_xs_coll),
        .tx_jabber(tx_jabber), .tx_crc_bad(tx_crc_bad),
        .tx_oversize(tx_oversize), .tx_undersize(tx_undersize),
        .tx_fragment(tx_fragment), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 5'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rx_frame(input int len, input bit tag, input bit crc,
                            input bit aln, input bit cut);
        @(negedge clk);
        rx_done = 1; rx_len = 16'(len); rx_tagged = tag;
        rx_crc_bad = crc; rx_align_bad = aln; rx_cut = cut;
        @(negedge clk);
        rx_done = 0;
    endtask

    task automatic tx_frame(input int nb, input int coll, input bit ok,
                            input logic [10:0] f);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); tx_byte_stb = 1; tx_byte_ovh = 1;
        end
        for (int k = 0; k < nb; k++) begin
            @(negedge clk); tx_byte_stb = 1; tx_byte_ovh = 0;
        end
        if (coll != 0) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk); tx_byte_stb = 1; tx_byte_ovh = 1;
            end
        end
        @(negedge clk);
        tx_byte_stb = 0; tx_byte_ovh = 0;
        tx_done = 1; tx_sent_ok = ok; tx_coll_cnt = 5'(coll);
        {tx_fragment, tx_undersize, tx_oversize, tx_crc_bad, tx_jabber,
         tx_xs_coll, tx_late_coll, tx_xdeferred, tx_deferred, tx_bcast,
         tx_mcast} = f;
        @(negedge clk);
        tx_done = 0;
    endtask

    initial begin
        #(PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 21; i++) exp_w[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: every index zero after reset
        for (int a = 0; a < 32; a++) begin
            rd(a, d); check("R1 reset", d, 32'd0);
        end

        // R2 R3 R4: sweep lengths across both limits, all error/tag/cut mixes
        for (int len = 1514; len <= 1527; len++)
            for (int tag = 0; tag < 2; tag++)
                for (int err = 0; err < 4; err++)
                    for (int cut = 0; cut < 2; cut++) begin
                        rx_frame(len, tag[0], err[0], err[1], cut[0]);
                        if (len > (tag != 0 ? 1522 : 1518) && err != 0 && cut == 0)
                            rxj_exp++;
                        rd(0, d);
                        check("R2 R3 R4 rx jabber", d, 32'(rxj_exp));
                    end

        // R10: write wins over same-cycle jabber increment
        @(negedge clk);
        reg_wr = 1; reg_addr = 0; reg_wdata = 32'd5;
        rx_done = 1; rx_len = 16'd1600; rx_tagged = 0; rx_crc_bad = 1;
        rx_align_bad = 0; rx_cut = 0;
        @(negedge clk);
        reg_wr = 0; rx_done = 0;
        rd(0, d); check("R10 rx write wins", d, 32'd5);

        // R9 R11: upper bits dropped, then saturate on increments
        wr(0, 32'hFFFF_FFFE);
        rd(0, d); check("R9 rx width", d, 32'h0000_0FFE);
        rx_frame(1600, 0, 1, 0, 0);
        rd(0, d); check("R11 rx reach max", d, 32'h0000_0FFF);
        rx_frame(1600, 1, 0, 1, 0);
        rd(0, d); check("R11 rx saturate", d, 32'h0000_0FFF);

        // R5 R6 R7: transmit sweep with computed model
        for (int i = 0; i < 80; i++) begin
            int nb, coll;
            bit ok;
            logic [10:0] f;
            nb = (i % 7) + 1;
            coll = i % 17;
            ok = (i % 3) != 0;
            f = 11'((i * 173) ^ (i << 4) ^ (i >> 1));
            tx_frame(nb, coll, ok, f);
            exp_w[1] += nb;
            exp_w[2] += 1;
            for (int b = 0; b < 11; b++) if (f[b]) exp_w[flag_word[b]] += 1;
            if (ok && coll == 1) exp_w[8] += 1;
            if (ok && coll >= 2 && coll <= 15) exp_w[9] += 1;
            exp_w[12] += coll;
        end
        for (int a = 1; a < 21; a++) begin
            rd(a, d);
            if (a == 1)       check("R5 tx bytes", d, 32'(exp_w[a]));
            else if (a == 8 || a == 9 || a == 12)
                              check("R7 tx collisions", d, 32'(exp_w[a]));
            else              check("R6 R8 tx frame counters", d, 32'(exp_w[a]));
        end

        // R10: byte count write wins over same-cycle strobe
        @(negedge clk);
        reg_wr = 1; reg_addr = 1; reg_wdata = 32'd100;
        tx_byte_stb = 1; tx_byte_ovh = 0;
        @(negedge clk);
        reg_wr = 0; tx_byte_stb = 0;
        rd(1, d); check("R10 tx write wins", d, 32'd100);

        // R9 R11: byte count width and saturation
        wr(1, 32'hFFFF_FFFF);
        rd(1, d); check("R9 byte width", d, 32'h00FF_FFFF);
        @(negedge clk); tx_byte_stb = 1; tx_byte_ovh = 0;
        @(negedge clk); tx_byte_stb = 0;
        rd(1, d); check("R11 byte saturate", d, 32'h00FF_FFFF);

        // R9: generic counter width
        wr(2, 32'hFFFF_FFFF);
        rd(2, d); check("R9 event width", d, 32'((1 << EVT_W) - 1));

        // R8: reserved and unmapped ignore writes
        wr(5, 32'hFFFF_FFFF);
        rd(5, d); check("R8 reserved", d, 32'd0);
        wr(17, 32'h1234_5678);
        rd(17, d); check("R8 reserved", d, 32'd0);
        wr(25, 32'hFFFF_FFFF);
        rd(25, d); check("R8 unmapped", d, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule